// File: doc/BRIEF.md
# Universal Shift and Storage Register with Shared Bidirectional Data Pads

This block holds a parameterised word (eight bits by default) and moves it in one of four ways on each rising clock edge: it keeps the word, shifts it toward the high stage, shifts it toward the low stage, or captures a new word in parallel. One set of data pads serves both directions. The register drives its contents onto the pads when it is allowed to, and it reads a new word from the same pads when it loads. The pads are modelled as separate pad-in, pad-out and pad-enable signals, so a pad ring or a tri-state bus wrapper can be placed around them.

The pad drivers are turned off in two cases. The first is while the load mode is selected, so the pads can act as inputs. The second is while either of two active-high float requests is asserted. Turning the drivers off never stops the register: shifting, loading and clearing carry on behind disabled pads. Two serial outputs show the lowest stage and the highest stage at all times. They let several of these registers be chained. An asynchronous active-low clear empties the word and takes priority over every mode.

Top module: `shreg_bidir`

## Requirements
- R1: While `clr_n` is low, the stored word is zero at once, without a clock edge, and `tap_lo` and `tap_hi` both read 0.
- R2: With `mode_sel` = 2'b00, a rising edge leaves the stored word unchanged.
- R3: With `mode_sel` = 2'b01, a rising edge moves bit i into bit i+1 for every i below WIDTH-1, and `ser_up` enters bit 0.
- R4: With `mode_sel` = 2'b10, a rising edge moves bit i+1 into bit i for every i below WIDTH-1, and `ser_down` enters bit WIDTH-1.
- R5: With `mode_sel` = 2'b11, a rising edge stores the value present on `pad_in` (pad bit i goes to stage bit i).
- R6: While `mode_sel` = 2'b11, `pad_oe` is 0 whatever `float_a` and `float_b` are.
- R7: While `float_a` or `float_b` is 1, `pad_oe` is 0.
- R8: In any mode other than 2'b11, with both float requests at 0, `pad_oe` is 1 and `pad_out` carries the stored word.
- R9: A disabled pad driver (R6 or R7) has no effect on shifting, holding or loading. The word updates exactly as in R2 to R5.
- R10: `tap_lo` always equals stored bit 0 and `tap_hi` always equals stored bit WIDTH-1, with no gating by `pad_oe`.
- R11: Clear overrides every mode. While `clr_n` is low, clock edges in any mode, including load, leave the word at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode_sel | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 parallel load |
| float_a | input | 1 | Float request A; high turns the pad drivers off |
| float_b | input | 1 | Float request B; high turns the pad drivers off |
| ser_up | input | 1 | Serial bit entering stage 0 on an upward shift |
| ser_down | input | 1 | Serial bit entering stage WIDTH-1 on a downward shift |
| pad_in | input | WIDTH | Value sampled from the shared pads |
| pad_out | output | WIDTH | Value offered to the shared pads |
| pad_oe | output | 1 | Pad driver enable, common to all bits |
| tap_lo | output | 1 | Stage 0, always driven |
| tap_hi | output | 1 | Stage WIDTH-1, always driven |

## Verification
The functions most likely to collide are a float request turning the drivers off and a mode that changes the register in the same cycle. Examples are a shift while `float_b` is high, or a load that takes the pads away while `float_a` is also high. A long sweep steps through every mode against every float pair, with varying serial and pad data. Each cycle, a word model in the bench judges the taps and the visible word after the edge and the pad enable before it. Clear is also pulsed low while load mode and fresh pad data are applied, so that clear and load meet on the same edges. The taps are then expected to stay at zero.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    typedef enum logic [1:0] {
        MODE_KEEP = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DOWN = 2'b10,
        MODE_LOAD = 2'b11
    } shreg_mode_e;

endpackage

// File: rtl/shreg_stage_mux.sv
module shreg_stage_mux
    import shreg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  shreg_mode_e        mode,
    input  logic [WIDTH-1:0]   cur,
    input  logic [WIDTH-1:0]   pad_in,
    input  logic               ser_up,
    input  logic               ser_down,
    output logic [WIDTH-1:0]   nxt
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic from_below;
        logic from_above;

        if (i == 0) begin : g_first
            assign from_below = ser_up;
        end else begin : g_mid_lo
            assign from_below = cur[i-1];
        end

        if (i == WIDTH - 1) begin : g_last
            assign from_above = ser_down;
        end else begin : g_mid_hi
            assign from_above = cur[i+1];
        end

        always_comb begin
            unique case (mode)
                MODE_KEEP: nxt[i] = cur[i];
                MODE_UP:   nxt[i] = from_below;
                MODE_DOWN: nxt[i] = from_above;
                MODE_LOAD: nxt[i] = pad_in[i];
                default:   nxt[i] = cur[i];
            endcase
        end
    end

endmodule

// File: rtl/shreg_drive_ctl.sv
module shreg_drive_ctl
    import shreg_pkg::*;
(
    input  shreg_mode_e mode,
    input  logic        float_a,
    input  logic        float_b,
    output logic        drive_en
);

    logic load_sel;
    logic float_any;

    always_comb begin
        load_sel  = (mode == MODE_LOAD);
        float_any = float_a | float_b;
        drive_en  = !(load_sel || float_any);
    end

    // R6: load mode always releases the pads
    always_comb begin
        if (mode == MODE_LOAD) begin
            a_r6_load_releases: assert (drive_en == 1'b0);
        end
    end

    // R7: either float request releases the pads
    always_comb begin
        if (float_a || float_b) begin
            a_r7_float_releases: assert (drive_en == 1'b0);
        end
    end

endmodule

// File: rtl/shreg_bidir.sv
module shreg_bidir
    import shreg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       mode_sel,
    input  logic             float_a,
    input  logic             float_b,
    input  logic             ser_up,
    input  logic             ser_down,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic             pad_oe,
    output logic             tap_lo,
    output logic             tap_hi
);

    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } state_t;

    state_t           state_d;
    state_t           state_q;
    shreg_mode_e      mode;
    logic [WIDTH-1:0] word_next;
    logic             drive_en;

    assign mode = shreg_mode_e'(mode_sel);

    shreg_stage_mux #(
        .WIDTH (WIDTH)
    ) u_mux (
        .mode     (mode),
        .cur      (state_q.word),
        .pad_in   (pad_in),
        .ser_up   (ser_up),
        .ser_down (ser_down),
        .nxt      (word_next)
    );

    shreg_drive_ctl u_drive (
        .mode     (mode),
        .float_a  (float_a),
        .float_b  (float_b),
        .drive_en (drive_en)
    );

    always_comb begin
        state_d      = state_q;
        state_d.word = word_next;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pad_out = state_q.word;
    assign pad_oe  = drive_en;
    assign tap_lo  = state_q.word[0];
    assign tap_hi  = state_q.word[TOP];

    // R1 / R11: taps read low whenever clear is held
    a_r1_clear_taps: assert property (@(posedge clk)
        !clr_n |-> (tap_lo == 1'b0 && tap_hi == 1'b0));

    // R2: hold keeps the word
    a_r2_keep: assert property (@(posedge clk) disable iff (!clr_n)
        mode_sel == 2'b00 |=> $stable(pad_out));

    // R3: upward shift takes the serial bit into stage 0
    a_r3_up_entry: assert property (@(posedge clk) disable iff (!clr_n)
        mode_sel == 2'b01 |=> tap_lo == $past(ser_up));

    // R4: downward shift takes the serial bit into the top stage
    a_r4_down_entry: assert property (@(posedge clk) disable iff (!clr_n)
        mode_sel == 2'b10 |=> tap_hi == $past(ser_down));

    // R5: load captures the pads
    a_r5_load: assert property (@(posedge clk) disable iff (!clr_n)
        mode_sel == 2'b11 |=> pad_out == $past(pad_in));

    // R9: a float request does not freeze an upward shift
    a_r9_float_shift: assert property (@(posedge clk) disable iff (!clr_n)
        (mode_sel == 2'b01 && (float_a || float_b)) |=> tap_lo == $past(ser_up));

endmodule

// File: tb/sim_shreg_bidir.sv
module sim_shreg_bidir;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic [1:0]   mode_sel = 2'b00;
    logic         float_a = 1'b0;
    logic         float_b = 1'b0;
    logic         ser_up = 1'b0;
    logic         ser_down = 1'b0;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_out;
    logic         pad_oe;
    logic         tap_lo;
    logic         tap_hi;

    int n_run  = 0;
    int n_fail = 0;
    logic [W-1:0] model = '0;
    logic [15:0]  lfsr  = 16'hACE1;

    always #2 clk = ~clk;

    shreg_bidir #(.WIDTH(W)) u0 (
        .clk(clk), .clr_n(clr_n), .mode_sel(mode_sel),
        .float_a(float_a), .float_b(float_b),
        .ser_up(ser_up), .ser_down(ser_down),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .tap_lo(tap_lo), .tap_hi(tap_hi)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] next_word(input logic [1:0] m, input logic [W-1:0] w,
                                               input logic su, input logic sd,
                                               input logic [W-1:0] pin);
        case (m)
            2'b00:   return w;
            2'b01:   return {w[W-2:0], su};
            2'b10:   return {sd, w[W-1:1]};
            default: return pin;
        endcase
    endfunction

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        #40000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // Reset state, R1 and R10
        #1;
        check("R1 tap_lo in clear", tap_lo, 0);
        check("R1 tap_hi in clear", tap_hi, 0);
        @(negedge clk);
        @(negedge clk);
        check("R1 word after clear", pad_out, 0);
        clr_n = 1'b1;
        model = '0;

        // Sweep: every mode against every float pair, pseudo-random data
        for (int c = 0; c < 4000; c++) begin
            logic exp_oe;
            logic dis;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mode_sel = c[1:0];
            float_a  = c[2];
            float_b  = c[3];
            ser_up   = lfsr[0];
            ser_down = lfsr[5];
            pad_in   = lfsr[15:8] ^ c[11:4];
            #1;
            exp_oe = (mode_sel != 2'b11) && !float_a && !float_b;
            dis    = !exp_oe;
            if (mode_sel == 2'b11)           check("R6 pad_oe in load", pad_oe, 0);
            else if (float_a || float_b)     check("R7 pad_oe floated", pad_oe, 0);
            else begin
                check("R8 pad_oe enabled", pad_oe, 1);
                check("R8 pad_out word", pad_out, model);
            end
            model = next_word(mode_sel, model, ser_up, ser_down, pad_in);
            @(negedge clk);
            if (dis) check($sformatf("R9 word while released (%s)", mode_tag(mode_sel)), pad_out, model);
            else     check(mode_tag(mode_sel), pad_out, model);
            check("R10 tap_lo", tap_lo, model[0]);
            check("R10 tap_hi", tap_hi, model[W-1]);
        end

        // R11: clear meets load with nonzero pad data
        mode_sel = 2'b11;
        float_a  = 1'b0;
        float_b  = 1'b0;
        pad_in   = 8'hFF;
        @(negedge clk);
        check("R5 load FF", pad_out, 8'hFF);
        #1 clr_n = 1'b0;
        #0.5;
        check("R1 async clear word", pad_out, 0);
        check("R1 async clear tap_lo", tap_lo, 0);
        check("R1 async clear tap_hi", tap_hi, 0);
        for (int k = 0; k < 4; k++) begin
            pad_in = 8'hA5 ^ 8'(k);
            @(negedge clk);
            check("R11 clear beats load", pad_out, 0);
            check("R11 tap_hi held low", tap_hi, 0);
        end
        mode_sel = 2'b10;
        ser_down = 1'b1;
        @(negedge clk);
        check("R11 clear beats shift", pad_out, 0);
        clr_n = 1'b1;
        @(negedge clk);
        check("R4 shift after clear", pad_out, 8'h80);
        check("R10 tap_hi after clear", tap_hi, 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule